// File: doc/BRIEF.md
# MA Byte Payload Label and Multiframe Extractor

This receive-side block takes the maintenance-and-adaptation byte of each incoming 34 Mbit/s frame on a valid/ready stream, one byte per frame. It never applies back-pressure: `ma_ready` is tied high, and a byte counts as a frame exactly in a cycle where `ma_valid` is high. Bit 1 of the byte, the first one sent, is `ma_data[7]`. Bit 8 is `ma_data[0]`.

The three-bit payload label in `ma_data[5:3]` goes through a persistence filter. A value is taken into the stored label only after it has appeared in five frames in a row. The block keeps a sticky change flag and an unstable flag. It compares the stored label with a label supplied by software and reports a mismatch. The labels 000 and 001 have special matching rules.

The three trailing bits in `ma_data[2:0]` are handled in one of two ways, chosen by `mf_mode`. In integrated mode they pass through the same persistence filter and are stored as a three-bit value. In extracted mode, `ma_data[2:1]` gives the multiframe phase and `ma_data[0]` carries one bit of a four-bit timing-source word. That word is committed only when a complete multiframe has been received in order.

Top module: `ma_label_mf_rx`

## Requirements
- R1: The payload label `ma_data[5:3]` is written to `pt_value` one cycle after the fifth consecutive frame that carries the same label.
- R2: A run of fewer than five equal labels leaves `pt_value` unchanged.
- R3: `pt_chg` is set when `pt_value` changes, and it stays set until `pt_chg_clr` is pulsed. When a change and a clear fall in the same cycle, the set wins.
- R4: `pt_unstable` rises after eight consecutive frames in which no label has persisted for five frames. It falls when a label persists again.
- R5: `pt_mismatch` is computed as follows:
  - If either the expected label or the stored label is 000, the flag is high whenever the two labels differ.
  - Otherwise, if either label is 001, the flag is low.
  - Otherwise, the flag is high whenever the two labels differ.
- R6: With `mf_mode`=0, `ma_data[2:0]` is filtered with the same five-frame rule and stored as `mf_value` = {0, bits}.
- R7: With `mf_mode`=1, `ma_data[2:1]` is the phase and `ma_data[0]` is the bit. Phases 00, 01, 10 and 11 in order carry word bits 3, 2, 1 and 0. The word is written to `mf_value` one cycle after the phase-11 frame.
- R8: A phase received out of order abandons the word being gathered. An out-of-order phase 00 starts a new word, and any other out-of-order phase waits for the next 00.
- R9: `mf_chg` is set when `mf_value` changes, and it stays set until `mf_chg_clr` is pulsed.
- R10: `ma_ready` is always 1. Data presented while `ma_valid` is low has no effect.
- R11: After reset, all stored values, counters and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ma_valid | input | 1 | One MA byte present this cycle |
| ma_ready | output | 1 | Always high |
| ma_data | input | 8 | MA byte, bit 1 at MSB |
| exp_label | input | 3 | Expected payload label |
| mf_mode | input | 1 | 0 integrated, 1 multiframe extraction |
| pt_chg_clr | input | 1 | Clears pt_chg |
| mf_chg_clr | input | 1 | Clears mf_chg |
| pt_value | output | 3 | Accepted payload label |
| pt_chg | output | 1 | Sticky label change |
| pt_unstable | output | 1 | No persistent label for 8 frames |
| pt_mismatch | output | 1 | Label compare result |
| mf_value | output | 4 | Stored multiframe / timing value |
| mf_chg | output | 1 | Sticky mf_value change |

## Verification
The bench feeds runs of four equal labels, which must not be accepted. A filter that counts one frame short would accept them and move `pt_value` early. It breaks a run with one foreign frame and then resumes it, to expose a filter that does not restart its count. It drives multiframes with a skipped phase and with a repeated phase 00. A collector that ignores phase order would commit a garbled word. The bench walks the 000/001 matching corners, where a plain equality compare gives the wrong answer. It also counts exactly to the eighth unsettled frame, which catches an off-by-one in the unstable counter.

// File: rtl/ma_rx_pkg.sv
package ma_rx_pkg;
  localparam int MA_W   = 8;
  localparam int LBL_W  = 3;
  localparam int MF_LEN = 4;
  localparam int PH_W   = $clog2(MF_LEN);

  typedef logic [LBL_W-1:0] label_t;

  // 000 and 001 are special: 000 only agrees with 000, 001 agrees with any non-000.
  function automatic logic label_mismatch(label_t want, label_t got);
    if (want == '0 || got == '0)
      return want != got;
    else if (want == label_t'(1) || got == label_t'(1))
      return 1'b0;
    else
      return want != got;
  endfunction
endpackage

// File: rtl/ma_integ.sv
module ma_integ #(
  parameter int W     = 3,
  parameter int RUN_N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] cand,
  output logic         held
);
  localparam int CW = $clog2(RUN_N + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= '0;
      run  <= '0;
      held <= 1'b0;
    end else if (stb) begin
      if (din != cand) begin
        cand <= din;
        run  <= CW'(1);
        held <= (RUN_N == 1);
      end else if (run < CW'(RUN_N)) begin
        run <= run + CW'(1);
        if (run == CW'(RUN_N - 1)) held <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mf_collect.sv
module mf_collect
  import ma_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb,
  input  logic [PH_W-1:0]   phase,
  input  logic              bit_in,
  output logic              commit,
  output logic [MF_LEN-1:0] word
);
  logic [PH_W-1:0]   nxt;
  logic [MF_LEN-1:0] acc;
  localparam logic [PH_W-1:0] LAST = PH_W'(MF_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt    <= '0;
      acc    <= '0;
      word   <= '0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (!en) begin
        nxt <= '0;
      end else if (stb) begin
        if (phase == nxt) begin
          acc[LAST - phase] <= bit_in;
          if (phase == LAST) begin
            word   <= {acc[MF_LEN-1:1], bit_in};
            commit <= 1'b1;
            nxt    <= '0;
          end else begin
            nxt <= phase + PH_W'(1);
          end
        end else if (phase == '0) begin
          acc[LAST] <= bit_in;
          nxt       <= PH_W'(1);
        end else begin
          nxt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ma_label_mf_rx.sv
module ma_label_mf_rx
  import ma_rx_pkg::*;
#(
  parameter int INTEG_N  = 5,
  parameter int UNSTAB_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ma_valid,
  output logic        ma_ready,
  input  logic [7:0]  ma_data,
  input  logic [2:0]  exp_label,
  input  logic        mf_mode,
  input  logic        pt_chg_clr,
  input  logic        mf_chg_clr,
  output logic [2:0]  pt_value,
  output logic        pt_chg,
  output logic        pt_unstable,
  output logic        pt_mismatch,
  output logic [3:0]  mf_value,
  output logic        mf_chg
);
  localparam int UW = $clog2(UNSTAB_N + 1);

  logic         stb, frm_q;
  label_t       pt_cand, mf_cand;
  logic         pt_held, pt_held_q, mf_held, mf_held_q;
  logic         pt_rise, mf_rise;
  logic         col_commit;
  logic [3:0]   col_word;
  logic         mf_store;
  logic [3:0]   mf_new;
  logic [UW-1:0] ucnt;

  assign ma_ready = 1'b1;
  assign stb      = ma_valid & ma_ready;

  ma_integ #(.W(LBL_W), .RUN_N(INTEG_N)) u_pt_integ (
    .clk(clk), .rst_n(rst_n), .stb(stb), .din(ma_data[5:3]),
    .cand(pt_cand), .held(pt_held)
  );

  ma_integ #(.W(LBL_W), .RUN_N(INTEG_N)) u_mf_integ (
    .clk(clk), .rst_n(rst_n), .stb(stb), .din(ma_data[2:0]),
    .cand(mf_cand), .held(mf_held)
  );

  mf_collect u_mf_col (
    .clk(clk), .rst_n(rst_n), .en(mf_mode), .stb(stb),
    .phase(ma_data[2:1]), .bit_in(ma_data[0]),
    .commit(col_commit), .word(col_word)
  );

  assign pt_rise  = pt_held & ~pt_held_q;
  assign mf_rise  = mf_held & ~mf_held_q;
  assign mf_store = mf_mode ? col_commit : mf_rise;
  assign mf_new   = mf_mode ? col_word : {1'b0, mf_cand};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt_held_q <= 1'b0;
      mf_held_q <= 1'b0;
      frm_q     <= 1'b0;
    end else begin
      pt_held_q <= pt_held;
      mf_held_q <= mf_held;
      frm_q     <= stb;
    end
  end

  // Payload label store with sticky change flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt_value <= '0;
      pt_chg   <= 1'b0;
    end else if (pt_rise && pt_cand != pt_value) begin
      pt_value <= pt_cand;
      pt_chg   <= 1'b1;
    end else if (pt_chg_clr) begin
      pt_chg <= 1'b0;
    end
  end

  // Frames without a persistent label
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ucnt        <= '0;
      pt_unstable <= 1'b0;
    end else if (frm_q) begin
      if (pt_held) begin
        ucnt        <= '0;
        pt_unstable <= 1'b0;
      end else if (ucnt < UW'(UNSTAB_N)) begin
        ucnt <= ucnt + UW'(1);
        if (ucnt == UW'(UNSTAB_N - 1)) pt_unstable <= 1'b1;
      end
    end
  end

  // Multiframe / timing value store
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_value <= '0;
      mf_chg   <= 1'b0;
    end else if (mf_store && mf_new != mf_value) begin
      mf_value <= mf_new;
      mf_chg   <= 1'b1;
    end else if (mf_chg_clr) begin
      mf_chg <= 1'b0;
    end
  end

  assign pt_mismatch = label_mismatch(exp_label, pt_value);
endmodule

// File: rtl/ma_label_mf_chk.sv
module ma_label_mf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pt_rise,
  input logic [2:0] pt_value,
  input logic       pt_chg,
  input logic       pt_unstable,
  input logic       pt_mismatch,
  input logic [2:0] exp_label,
  input logic [3:0] mf_value,
  input logic       mf_chg
);
  AST_PT_ONLY_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pt_value) |-> $past(pt_rise)); // R1
  AST_PT_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pt_value) |-> pt_chg); // R3
  AST_UNSTAB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pt_rise) |-> !pt_unstable); // R4
  AST_EQUAL_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_value == exp_label) |-> !pt_mismatch); // R5
  AST_MF_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mf_value) |-> mf_chg); // R9
endmodule

bind ma_label_mf_rx ma_label_mf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pt_rise(pt_rise), .pt_value(pt_value),
  .pt_chg(pt_chg), .pt_unstable(pt_unstable), .pt_mismatch(pt_mismatch),
  .exp_label(exp_label), .mf_value(mf_value), .mf_chg(mf_chg)
);

// File: tb/tb_ma_label_mf_rx.sv
module tb_ma_label_mf_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ma_valid = 1'b0;
  logic       ma_ready;
  logic [7:0] ma_data = '0;
  logic [2:0] exp_label = '0;
  logic       mf_mode = 1'b0;
  logic       pt_chg_clr = 1'b0;
  logic       mf_chg_clr = 1'b0;
  logic [2:0] pt_value;
  logic       pt_chg, pt_unstable, pt_mismatch;
  logic [3:0] mf_value;
  logic       mf_chg;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ma_label_mf_rx dut (.*);

  // {mode, byte, expected label, expected mf value}
  localparam int NV = 27;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 8'h2B, 3'd0, 4'h0}, {1'b0, 8'h2B, 3'd0, 4'h0},
    {1'b0, 8'h2B, 3'd0, 4'h0}, {1'b0, 8'h2B, 3'd0, 4'h0},
    {1'b0, 8'h2B, 3'd5, 4'h3}, {1'b0, 8'h00, 3'd5, 4'h3},
    {1'b0, 8'h2B, 3'd5, 4'h3}, {1'b0, 8'h2B, 3'd5, 4'h3},
    {1'b0, 8'h2B, 3'd5, 4'h3}, {1'b0, 8'h2B, 3'd5, 4'h3},
    {1'b0, 8'hD6, 3'd5, 4'h3}, {1'b0, 8'hD6, 3'd5, 4'h3},
    {1'b0, 8'hD6, 3'd5, 4'h3}, {1'b0, 8'hD6, 3'd5, 4'h3},
    {1'b0, 8'hD6, 3'd2, 4'h6},
    {1'b1, 8'h11, 3'd2, 4'h6}, {1'b1, 8'h12, 3'd2, 4'h6},
    {1'b1, 8'h15, 3'd2, 4'h6}, {1'b1, 8'h17, 3'd2, 4'hB},
    {1'b1, 8'h10, 3'd2, 4'hB}, {1'b1, 8'h13, 3'd2, 4'hB},
    {1'b1, 8'h17, 3'd2, 4'hB}, {1'b1, 8'h14, 3'd2, 4'hB},
    {1'b1, 8'h10, 3'd2, 4'hB}, {1'b1, 8'h13, 3'd2, 4'hB},
    {1'b1, 8'h15, 3'd2, 4'hB}, {1'b1, 8'h16, 3'd2, 4'h6}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    ma_valid = 1'b1;
    ma_data  = b;
    @(negedge clk);
    ma_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_n(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    pt_chg_clr = 1'b1;
    mf_chg_clr = 1'b1;
    @(negedge clk);
    pt_chg_clr = 1'b0;
    mf_chg_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic mm(input logic [2:0] e, input int expv);
    exp_label = e;
    #1;
    check("R5 mismatch", pt_mismatch, expv);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 pt_value", pt_value, 0);
    check("R11 mf_value", mf_value, 0);
    check("R11 flags", {pt_chg, pt_unstable, mf_chg, pt_mismatch}, 0);
    check("R10 ready", ma_ready, 1);

    for (int i = 0; i < NV; i++) begin
      mf_mode = VEC[i][15];
      send(VEC[i][14:7]);
      check(VEC[i][15] ? "R7 R8 R2 label" : "R1 R2 label", pt_value, VEC[i][6:4]);
      check(VEC[i][15] ? "R7 R8 mf" : "R6 mf", mf_value, VEC[i][3:0]);
    end

    check("R3 pt_chg set", pt_chg, 1);
    check("R9 mf_chg set", mf_chg, 1);
    pulse_clr();
    check("R3 pt_chg cleared", pt_chg, 0);
    check("R9 mf_chg cleared", mf_chg, 0);

    // R4 unstable counting
    for (int i = 0; i < 7; i++) send((i % 2 == 0) ? 8'h08 : 8'h10);
    check("R4 unstable after 7", pt_unstable, 0);
    send(8'h10);
    check("R4 unstable after 8", pt_unstable, 1);
    send_n(8'h08, 4);
    check("R4 still unstable", pt_unstable, 1);
    send(8'h08);
    check("R4 unstable cleared", pt_unstable, 0);
    check("R1 label 1", pt_value, 1);
    check("R3 pt_chg on change", pt_chg, 1);

    // R5 matching corners
    mm(3'd0, 1);
    mm(3'd1, 0);
    mm(3'd5, 0);
    send_n(8'h00, 5);
    check("R1 label 0", pt_value, 0);
    mm(3'd0, 0);
    mm(3'd1, 1);
    mm(3'd6, 1);
    send_n(8'h30, 5);
    check("R1 label 6", pt_value, 6);
    mm(3'd6, 0);
    mm(3'd3, 1);
    mm(3'd1, 0);
    mm(3'd0, 1);

    // R10 data ignored while valid low
    @(negedge clk);
    ma_data = 8'h3F;
    repeat (10) @(negedge clk);
    check("R10 label held", pt_value, 6);
    check("R10 ready", ma_ready, 1);

    // R8 repeated phase 00 never commits
    check("R8 mf unchanged", mf_value, 6);
    check("R9 mf_chg stays clear", mf_chg, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule